// File: doc/BRIEF.md
# Display Controller Command Parser

This block reads a stream of bytes from a host. Each byte carries a flag that marks it as an opcode or as an argument. The block decodes every opcode and knows how many argument bytes that opcode needs. It collects those arguments and, once the last one arrives, writes the settings held in its configuration registers.

The registers cover the following:

- a row window for partial display, with an enable for that mode;
- a choice between the internal regulator and an external supply;
- the display on/off state;
- the lengths of the two drive phases;
- the clock divide and oscillator frequency codes;
- the state codes for two general-purpose pins.

All registers drive output ports directly. Each time a command completes, the block pulses `cmd_done` for one cycle and shows the opcode on `cmd_code`.

Opcodes that need no argument take effect on the opcode byte alone. An opcode that the block does not recognise is consumed as one byte and changes nothing. A new opcode that arrives while arguments are still outstanding abandons the unfinished command and is decoded in its place.

Top module: `dispcmd_parser`

## Requirements
- R1: After reset the outputs hold these values: display off, partial mode off, internal regulator selected (`vreg_ext`=0), start row 0, end row ROWS-1 (7Fh at the default), phase1=4h, phase2=7h, clock divide code 0h (ratio 1), oscillator code 0h, GPIO state 0 and `cmd_done` low.
- R2: The opcode AEh turns the display off and AFh turns it on. Neither takes an argument.
- R3: The opcode A8h takes two argument bytes. Bits [6:0] of the first set the start row and bits [6:0] of the second set the end row; bit 7 of each is ignored. Partial mode turns on when the second argument is accepted. The window 20h..5Fh is accepted as given.
- R4: The opcode A9h turns partial mode off without argument and leaves the stored start and end rows unchanged.
- R5: The opcode ABh takes one argument. Its bit 0 sets `vreg_ext` (0 selects the internal regulator, 1 an external supply) and its other bits are ignored.
- R6: The opcode B1h takes one argument. Bits [3:0] go to `phase1` and bits [7:4] go to `phase2`.
- R7: The opcode B3h takes one argument. Bits [3:0] go to `clk_div` and bits [7:4] go to `osc_freq`.
- R8: The opcode B5h takes one argument. Bits [1:0] give the state of pin 0 and bits [3:2] the state of pin 1; both appear on `gpio_state[3:0]` in the same positions. Bits [7:4] are ignored.
- R9: `cmd_done` is high for exactly one cycle, in the cycle after the final byte of a recognised command is accepted. During that cycle `cmd_code` shows the opcode.
- R10: An unrecognised opcode is consumed as a single byte. It changes no register and raises no `cmd_done`, and a following argument byte is not taken as one of its arguments.
- R11: An opcode byte that arrives while arguments are pending abandons the pending command, with no register change from it. The byte is then decoded as a new opcode.
- R12: An argument byte that arrives while no command is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_ready | output | 1 | Block accepts a byte (high outside reset) |
| in_is_cmd | input | 1 | 1 = opcode byte, 0 = argument byte |
| in_byte | input | 8 | Byte value |
| disp_on | output | 1 | Display enabled |
| part_en | output | 1 | Partial display mode active |
| part_start | output | ROW_W | First row of partial window |
| part_end | output | ROW_W | Last row of partial window |
| vreg_ext | output | 1 | 1 = external supply, 0 = internal regulator |
| phase1 | output | 4 | Phase 1 length code |
| phase2 | output | 4 | Phase 2 length code |
| clk_div | output | 4 | Clock divide code (ratio minus one) |
| osc_freq | output | 4 | Oscillator frequency code |
| gpio_state | output | GPIO_PINS*GPIO_CW | Per-pin state codes |
| cmd_done | output | 1 | One-cycle pulse when a command completes |
| cmd_code | output | 8 | Opcode of the completed command |

## Verification
The hardest situation to reach from the ports is an opcode that arrives partway through a multi-byte command. This happens after the first of the two row arguments, and also while a one-argument command waits for its byte.

The stimulus starts both of these commands, then sends an opcode that has a visible effect, the display on/off command. This shows that the new byte was decoded. It then sends a stray argument byte and checks that the abandoned command neither completed nor picked up that byte.

// File: rtl/dispcmd_pkg.sv
package dispcmd_pkg;

   typedef enum logic [3:0] {
      K_NONE,
      K_PART_ON,
      K_PART_OFF,
      K_VREG,
      K_DOFF,
      K_DON,
      K_PHASE,
      K_CLK,
      K_GPIO
   } kind_e;

   localparam logic [7:0] OP_PART_ON  = 8'hA8;
   localparam logic [7:0] OP_PART_OFF = 8'hA9;
   localparam logic [7:0] OP_VREG     = 8'hAB;
   localparam logic [7:0] OP_DOFF     = 8'hAE;
   localparam logic [7:0] OP_DON      = 8'hAF;
   localparam logic [7:0] OP_PHASE    = 8'hB1;
   localparam logic [7:0] OP_CLK      = 8'hB3;
   localparam logic [7:0] OP_GPIO     = 8'hB5;

endpackage

// File: rtl/dispcmd_decode.sv
module dispcmd_decode
   import dispcmd_pkg::*;
(
   input  logic [7:0] op,
   output kind_e      kind,
   output logic [1:0] nargs
);

   always_comb begin
      kind  = K_NONE;
      nargs = 2'd0;
      case (op)
         OP_PART_ON:  begin kind = K_PART_ON;  nargs = 2'd2; end
         OP_PART_OFF: begin kind = K_PART_OFF; nargs = 2'd0; end
         OP_VREG:     begin kind = K_VREG;     nargs = 2'd1; end
         OP_DOFF:     begin kind = K_DOFF;     nargs = 2'd0; end
         OP_DON:      begin kind = K_DON;      nargs = 2'd0; end
         OP_PHASE:    begin kind = K_PHASE;    nargs = 2'd1; end
         OP_CLK:      begin kind = K_CLK;      nargs = 2'd1; end
         OP_GPIO:     begin kind = K_GPIO;     nargs = 2'd1; end
         default:     begin kind = K_NONE;     nargs = 2'd0; end
      endcase
   end

endmodule

// File: rtl/dispcmd_collect.sv
module dispcmd_collect
   import dispcmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc,
   input  logic       is_cmd,
   input  logic [7:0] byte_in,
   input  kind_e      kind_in,
   input  logic [1:0] nargs_in,
   output logic       commit,
   output kind_e      commit_kind,
   output logic [7:0] commit_op,
   output logic [7:0] first_arg,
   output logic [7:0] last_arg,
   output logic       busy
);

   logic       pending_q;
   logic [1:0] left_q;
   kind_e      held_kind_q;
   logic [7:0] held_op_q;
   logic [7:0] first_q;
   logic       have_first_q;

   assign busy      = pending_q;
   assign last_arg  = byte_in;
   assign first_arg = have_first_q ? first_q : byte_in;

   always_comb begin
      commit      = 1'b0;
      commit_kind = kind_in;
      commit_op   = byte_in;
      if (acc && is_cmd) begin
         commit = (kind_in != K_NONE) && (nargs_in == 2'd0);
      end else if (acc && pending_q && (left_q == 2'd1)) begin
         commit      = 1'b1;
         commit_kind = held_kind_q;
         commit_op   = held_op_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q    <= 1'b0;
         left_q       <= 2'd0;
         held_kind_q  <= K_NONE;
         held_op_q    <= 8'h00;
         first_q      <= 8'h00;
         have_first_q <= 1'b0;
      end else if (acc && is_cmd) begin
         pending_q    <= (kind_in != K_NONE) && (nargs_in != 2'd0);
         left_q       <= nargs_in;
         held_kind_q  <= kind_in;
         held_op_q    <= byte_in;
         have_first_q <= 1'b0;
      end else if (acc && pending_q) begin
         if (left_q == 2'd1) begin
            pending_q <= 1'b0;
            left_q    <= 2'd0;
         end else begin
            left_q       <= left_q - 2'd1;
            first_q      <= byte_in;
            have_first_q <= 1'b1;
         end
      end
   end

   // R11
   pend_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q |-> (left_q != 2'd0));

   // R11
   cmd_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_cmd) |=> !have_first_q);

endmodule

// File: rtl/dispcmd_regs.sv
module dispcmd_regs
   import dispcmd_pkg::*;
#(
   parameter int         ROW_W      = 7,
   parameter int         GPIO_PINS  = 2,
   parameter int         GPIO_CW    = 2,
   parameter logic [3:0] RST_PHASE1 = 4'h4,
   parameter logic [3:0] RST_PHASE2 = 4'h7,
   parameter logic [3:0] RST_OSC    = 4'h0,
   localparam int        GW         = GPIO_PINS * GPIO_CW
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  kind_e            kind,
   input  logic [7:0]       op,
   input  logic [7:0]       first_arg,
   input  logic [7:0]       last_arg,
   output logic             disp_on,
   output logic             part_en,
   output logic [ROW_W-1:0] part_start,
   output logic [ROW_W-1:0] part_end,
   output logic             vreg_ext,
   output logic [3:0]       phase1,
   output logic [3:0]       phase2,
   output logic [3:0]       clk_div,
   output logic [3:0]       osc_freq,
   output logic [GW-1:0]    gpio_state,
   output logic             cmd_done,
   output logic [7:0]       cmd_code
);

   localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_on    <= 1'b0;
         part_en    <= 1'b0;
         part_start <= '0;
         part_end   <= ROW_LAST;
         vreg_ext   <= 1'b0;
         phase1     <= RST_PHASE1;
         phase2     <= RST_PHASE2;
         clk_div    <= 4'h0;
         osc_freq   <= RST_OSC;
         cmd_done   <= 1'b0;
         cmd_code   <= 8'h00;
      end else begin
         cmd_done <= commit;
         if (commit) begin
            cmd_code <= op;
            case (kind)
               K_PART_ON: begin
                  part_start <= first_arg[ROW_W-1:0];
                  part_end   <= last_arg[ROW_W-1:0];
                  part_en    <= 1'b1;
               end
               K_PART_OFF: part_en  <= 1'b0;
               K_VREG:     vreg_ext <= last_arg[0];
               K_DOFF:     disp_on  <= 1'b0;
               K_DON:      disp_on  <= 1'b1;
               K_PHASE: begin
                  phase1 <= last_arg[3:0];
                  phase2 <= last_arg[7:4];
               end
               K_CLK: begin
                  clk_div  <= last_arg[3:0];
                  osc_freq <= last_arg[7:4];
               end
               default: ;
            endcase
         end
      end
   end

   for (genvar p = 0; p < GPIO_PINS; p++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gpio_state[p*GPIO_CW +: GPIO_CW] <= '0;
         else if (commit && (kind == K_GPIO))
            gpio_state[p*GPIO_CW +: GPIO_CW] <= last_arg[p*GPIO_CW +: GPIO_CW];
      end
   end

   // R6
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({phase2, phase1, clk_div, osc_freq, gpio_state}));

endmodule

// File: rtl/dispcmd_parser.sv
module dispcmd_parser
   import dispcmd_pkg::*;
#(
   parameter int         ROWS       = 128,
   parameter int         GPIO_PINS  = 2,
   parameter int         GPIO_CW    = 2,
   parameter logic [3:0] RST_PHASE1 = 4'h4,
   parameter logic [3:0] RST_PHASE2 = 4'h7,
   parameter logic [3:0] RST_OSC    = 4'h0,
   localparam int        ROW_W      = $clog2(ROWS),
   localparam int        GW         = GPIO_PINS * GPIO_CW
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_is_cmd,
   input  logic [7:0]       in_byte,
   output logic             disp_on,
   output logic             part_en,
   output logic [ROW_W-1:0] part_start,
   output logic [ROW_W-1:0] part_end,
   output logic             vreg_ext,
   output logic [3:0]       phase1,
   output logic [3:0]       phase2,
   output logic [3:0]       clk_div,
   output logic [3:0]       osc_freq,
   output logic [GW-1:0]    gpio_state,
   output logic             cmd_done,
   output logic [7:0]       cmd_code
);

   logic       acc;
   kind_e      dec_kind;
   logic [1:0] dec_nargs;
   logic       commit;
   kind_e      commit_kind;
   logic [7:0] commit_op;
   logic [7:0] first_arg;
   logic [7:0] last_arg;
   logic       busy;

   assign in_ready = rst_n;
   assign acc      = in_valid && in_ready;

   dispcmd_decode u_decode (
      .op    (in_byte),
      .kind  (dec_kind),
      .nargs (dec_nargs)
   );

   dispcmd_collect u_collect (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .is_cmd      (in_is_cmd),
      .byte_in     (in_byte),
      .kind_in     (dec_kind),
      .nargs_in    (dec_nargs),
      .commit      (commit),
      .commit_kind (commit_kind),
      .commit_op   (commit_op),
      .first_arg   (first_arg),
      .last_arg    (last_arg),
      .busy        (busy)
   );

   dispcmd_regs #(
      .ROW_W      (ROW_W),
      .GPIO_PINS  (GPIO_PINS),
      .GPIO_CW    (GPIO_CW),
      .RST_PHASE1 (RST_PHASE1),
      .RST_PHASE2 (RST_PHASE2),
      .RST_OSC    (RST_OSC)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .kind       (commit_kind),
      .op         (commit_op),
      .first_arg  (first_arg),
      .last_arg   (last_arg),
      .disp_on    (disp_on),
      .part_en    (part_en),
      .part_start (part_start),
      .part_end   (part_end),
      .vreg_ext   (vreg_ext),
      .phase1     (phase1),
      .phase2     (phase2),
      .clk_div    (clk_div),
      .osc_freq   (osc_freq),
      .gpio_state (gpio_state),
      .cmd_done   (cmd_done),
      .cmd_code   (cmd_code)
   );

   // R2
   disp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on != $past(disp_on)) |->
         $past(acc && in_is_cmd && (in_byte[7:1] == 7'h57)));

   // R3
   part_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(part_en) |-> $past(acc && !in_is_cmd));

   // R4
   part_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(part_en) |-> $past(acc && in_is_cmd && (in_byte == 8'hA9)));

   // R9
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> $past(acc));

   // R12
   idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_is_cmd && !busy) |=>
         (!cmd_done && $stable({disp_on, part_en, vreg_ext, phase1, phase2,
                                clk_div, osc_freq, gpio_state})));

endmodule

// File: tb/dispcmd_parser_tb.sv
module dispcmd_parser_tb;

   localparam int CLK_P = 10;
   localparam int NV    = 26;

   // {send, is_cmd, byte, sel, expected, req}
   // sel: 1 disp 2 part_en 3 start 4 end 5 vreg 6 {ph2,ph1} 7 {osc,div} 8 gpio 9 done?code:0
   localparam logic [25:0] VEC [NV] = '{
      {1'b1, 1'b1, 8'hAF, 4'd1, 8'h01, 4'd2},  // R2
      {1'b0, 1'b0, 8'h00, 4'd9, 8'h00, 4'd9},  // R9 pulse gone
      {1'b1, 1'b1, 8'hAE, 4'd1, 8'h00, 4'd2},  // R2
      {1'b1, 1'b1, 8'hAF, 4'd9, 8'hAF, 4'd9},  // R9
      {1'b1, 1'b1, 8'hA8, 4'd9, 8'h00, 4'd3},  // R3
      {1'b1, 1'b0, 8'hA0, 4'd9, 8'h00, 4'd3},  // R3
      {1'b1, 1'b0, 8'h5F, 4'd2, 8'h01, 4'd3},  // R3
      {1'b0, 1'b0, 8'h00, 4'd3, 8'h20, 4'd3},  // R3
      {1'b0, 1'b0, 8'h00, 4'd4, 8'h5F, 4'd3},  // R3
      {1'b1, 1'b1, 8'hA9, 4'd2, 8'h00, 4'd4},  // R4
      {1'b0, 1'b0, 8'h00, 4'd3, 8'h20, 4'd4},  // R4
      {1'b0, 1'b0, 8'h00, 4'd4, 8'h5F, 4'd4},  // R4
      {1'b1, 1'b1, 8'hAB, 4'd9, 8'h00, 4'd5},  // R5
      {1'b1, 1'b0, 8'h01, 4'd5, 8'h01, 4'd5},  // R5
      {1'b1, 1'b1, 8'hAB, 4'd5, 8'h01, 4'd5},  // R5
      {1'b1, 1'b0, 8'hFE, 4'd5, 8'h00, 4'd5},  // R5
      {1'b1, 1'b1, 8'hB1, 4'd6, 8'h74, 4'd6},  // R6
      {1'b1, 1'b0, 8'h5C, 4'd6, 8'h5C, 4'd6},  // R6
      {1'b1, 1'b1, 8'hB3, 4'd7, 8'h00, 4'd7},  // R7
      {1'b1, 1'b0, 8'h9E, 4'd7, 8'h9E, 4'd7},  // R7
      {1'b1, 1'b1, 8'hB5, 4'd8, 8'h00, 4'd8},  // R8
      {1'b1, 1'b0, 8'h6B, 4'd8, 8'h0B, 4'd8},  // R8
      {1'b1, 1'b0, 8'h3A, 4'd8, 8'h0B, 4'd12}, // R12
      {1'b1, 1'b1, 8'h42, 4'd9, 8'h00, 4'd10}, // R10
      {1'b1, 1'b0, 8'h11, 4'd6, 8'h5C, 4'd10}, // R10
      {1'b0, 1'b0, 8'h00, 4'd1, 8'h01, 4'd10}  // R10
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       in_is_cmd = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       disp_on, part_en, vreg_ext, cmd_done;
   logic [6:0] part_start, part_end;
   logic [3:0] phase1, phase2, clk_div, osc_freq, gpio_state;
   logic [7:0] cmd_code;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   dispcmd_parser u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_is_cmd  (in_is_cmd),
      .in_byte    (in_byte),
      .disp_on    (disp_on),
      .part_en    (part_en),
      .part_start (part_start),
      .part_end   (part_end),
      .vreg_ext   (vreg_ext),
      .phase1     (phase1),
      .phase2     (phase2),
      .clk_div    (clk_div),
      .osc_freq   (osc_freq),
      .gpio_state (gpio_state),
      .cmd_done   (cmd_done),
      .cmd_code   (cmd_code)
   );

   function automatic logic [7:0] view(input logic [3:0] sel);
      case (sel)
         4'd1: view = {7'd0, disp_on};
         4'd2: view = {7'd0, part_en};
         4'd3: view = {1'b0, part_start};
         4'd4: view = {1'b0, part_end};
         4'd5: view = {7'd0, vreg_ext};
         4'd6: view = {phase2, phase1};
         4'd7: view = {osc_freq, clk_div};
         4'd8: view = {4'd0, gpio_state};
         4'd9: view = cmd_done ? cmd_code : 8'h00;
         default: view = 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic send(input logic cmd, input logic [7:0] b);
      @(negedge clk);
      in_valid  = 1'b1;
      in_is_cmd = cmd;
      in_byte   = b;
      @(negedge clk);
      in_valid  = 1'b0;
      in_is_cmd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_reset();
      check("R1 disp", view(4'd1), 8'h00);
      check("R1 part_en", view(4'd2), 8'h00);
      check("R1 start", view(4'd3), 8'h00);
      check("R1 end", view(4'd4), 8'h7F);
      check("R1 vreg", view(4'd5), 8'h00);
      check("R1 phase", view(4'd6), 8'h74);
      check("R1 clk", view(4'd7), 8'h00);
      check("R1 gpio", view(4'd8), 8'h00);
      check("R1 done", {7'd0, cmd_done}, 8'h00);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      check_reset();

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][25])
            send(VEC[i][24], VEC[i][23:16]);
         else
            @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[i][3:0], i), view(VEC[i][15:12]), VEC[i][11:4]);
      end

      // R9: single-cycle pulse with opcode
      send(1'b1, 8'hAE);
      check("R9 pulse", view(4'd9), 8'hAE);
      @(negedge clk);
      check("R9 low", {7'd0, cmd_done}, 8'h00);

      // R11: abort one-argument command with a display opcode
      send(1'b1, 8'hB1);
      send(1'b1, 8'hAF);
      check("R11 new op", view(4'd1), 8'h01);
      check("R11 phase kept", view(4'd6), 8'h5C);
      send(1'b0, 8'h33);
      check("R11 stray arg", view(4'd6), 8'h5C);

      // R11: abort window command after its first argument
      send(1'b1, 8'hA8);
      send(1'b0, 8'h10);
      send(1'b1, 8'hAE);
      check("R11 new op2", view(4'd1), 8'h00);
      check("R11 start kept", view(4'd3), 8'h20);
      send(1'b0, 8'h30);
      check("R11 end kept", view(4'd4), 8'h5F);
      check("R11 part off", view(4'd2), 8'h00);

      // R3: full range, bit 7 ignored
      send(1'b1, 8'hA8);
      send(1'b0, 8'h80);
      send(1'b0, 8'hFF);
      check("R3 start0", view(4'd3), 8'h00);
      check("R3 end7F", view(4'd4), 8'h7F);
      check("R3 done", view(4'd9), 8'hA8);

      do_reset();
      check_reset();
      finish_run();
   end

endmodule